// File: doc/BRIEF.md
# Reset Controller with Start-up Timers

This block merges every reset cause of a chip into a single reset output that is raised at once on power-up and always released on a rising clock edge. The causes are power-on, the external reset pin (told apart by whether the chip was in a low-power mode), brown-out, watchdog time-out, a software reset instruction, stack full and stack underflow. Each cause input is a level that the block passes through a two-flop synchronizer before it acts. While a cause is active the reset stays asserted.

Power-on and brown-out resets are followed by two chained start-up delays. The first counts pulses of a slow tick enable, which stands for the slow internal clock. The second begins when the first expires and counts main-clock cycles so that the oscillator can settle. Every other cause is followed by a short fixed hold.

An 8-bit status register keeps active-low cause flags. An event clears them and software sets them again. The register also holds a brown-out software enable and an interrupt-priority enable. Software reads the flags together to identify the most recent reset.

Top module: `rst_ctrl`

## Requirements
- R1: While `por_ni` is low, `chip_rst_o` is 1 and `status_o` equals 8'h7C. Bit 0 is the brown-out flag, bit 1 the power-on flag, bit 2 the low-power flag, bit 3 the watchdog flag, bit 4 the instruction flag, bit 5 the stack flag, bit 6 the brown-out software enable and bit 7 the priority enable.
- R2: After `por_ni` rises, the first tick counted is the one sampled at the third rising edge. `chip_rst_o` falls at the rising edge 2**OST_BITS cycles after the edge that sampled the 2**PWRT_BITS-th counted tick.
- R3: An enabled brown-out input holds reset while high and clears status bit 0. After the input falls, the first tick counted is the one sampled at the fourth rising edge, and the release then follows the same two-timer rule as R2.
- R4: `cfg_bor_sel_i` 2'b00 ignores the brown-out input. 2'b01 lets it act only when status bit 6 is 1. 2'b10 and 2'b11 always let it act. An ignored input leaves `chip_rst_o` at 0 and `status_o` unchanged.
- R5: When `cfg_extpin_en_i` is 0, a low level on `ext_rst_ni` has no effect on `chip_rst_o` or `status_o`.
- R6: The pin, watchdog, instruction, stack-full and stack-underflow sources hold `chip_rst_o` at 1 while active. After the source input falls, `chip_rst_o` reads 0 after the (SHORT_CYC+3)-th rising edge.
- R7: Each event clears only its own flag. A pin reset with `lowpwr_i` high clears bit 2, and a pin reset with `lowpwr_i` low clears nothing. Watchdog clears bit 3, the instruction clears bit 4, and stack full or underflow clears bit 5.
- R8: Flags of events that did not occur keep their value, and without an event or a write the status register does not change.
- R9: A write with `sw_we_i` loads all eight bits of `sw_wdata_i`, which are visible after the next rising edge.
- R10: Bits 6 and 7 are unchanged by every reset except power-on.
- R11: A reset event that arrives while a start-up timer is running restarts the full two-timer sequence once that event is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main oscillator clock |
| por_ni | input | 1 | Power-on reset, active low, asynchronous |
| tick_i | input | 1 | Slow tick enable for the power-up timer |
| ext_rst_ni | input | 1 | External reset pin, active low |
| cfg_extpin_en_i | input | 1 | Configuration: external pin reset enabled |
| lowpwr_i | input | 1 | Chip is in a low-power mode |
| cfg_bor_sel_i | input | 2 | Configuration: brown-out gating mode |
| bor_evt_i | input | 1 | Brown-out detected |
| wdt_evt_i | input | 1 | Watchdog time-out |
| rst_instr_i | input | 1 | Software reset instruction |
| stk_full_i | input | 1 | Stack full |
| stk_unf_i | input | 1 | Stack underflow |
| sw_we_i | input | 1 | Status register write strobe |
| sw_wdata_i | input | 8 | Status register write data |
| status_o | output | 8 | Status register: cause flags and control bits |
| chip_rst_o | output | 1 | Chip reset, active high |

## Verification
The hardest case to reach is a second reset event that lands inside a running start-up timer, because the first event's timer must be partly elapsed when the second event arrives. The bench raises a brown-out, releases it, and lets a few cycles pass with the chip held in the power-up timer. It then raises a watchdog event and measures the release from the watchdog's falling edge against the full two-timer count. The bench drives the tick itself, so every hold time is computed exactly from the tick period and the timer widths.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    localparam int STATUS_W = 8;

    // status register bit positions
    localparam int FLG_BOR  = 0;
    localparam int FLG_POR  = 1;
    localparam int FLG_PD   = 2;
    localparam int FLG_TO   = 3;
    localparam int FLG_RI   = 4;
    localparam int FLG_STK  = 5;
    localparam int CTL_SBOR = 6;
    localparam int CTL_PRIO = 7;

    // value after power-on: brown-out and power-on flags cleared, soft BOR enabled
    localparam logic [STATUS_W-1:0] STATUS_POR_VAL = 8'h7C;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_PWRT,
        ST_OST,
        ST_SHORT,
        ST_RUN
    } seq_state_e;

    typedef struct packed {
        logic bor;
        logic pin;
        logic pin_lp;
        logic wdt;
        logic ri;
        logic stk;
    } evt_t;

endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/rstc_flags.sv
module rstc_flags
    import rstc_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                bor_i,
    input  logic                pd_i,
    input  logic                to_i,
    input  logic                ri_i,
    input  logic                stk_i,
    input  logic                we_i,
    input  logic [STATUS_W-1:0] wdata_i,
    output logic [STATUS_W-1:0] status_o
);

    logic [STATUS_W-1:0] stat_d, stat_q;

    always_comb begin
        stat_d = we_i ? wdata_i : stat_q;
        // an event clear wins over a same-cycle software write
        if (bor_i) stat_d[FLG_BOR] = 1'b0;
        if (pd_i)  stat_d[FLG_PD]  = 1'b0;
        if (to_i)  stat_d[FLG_TO]  = 1'b0;
        if (ri_i)  stat_d[FLG_RI]  = 1'b0;
        if (stk_i) stat_d[FLG_STK] = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stat_q <= STATUS_POR_VAL;
        else         stat_q <= stat_d;
    end

    assign status_o = stat_q;

    assert_wdt_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        to_i |=> !status_o[FLG_TO]);

    assert_ri_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ri_i |=> !status_o[FLG_RI]);

    assert_bor_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bor_i |=> !status_o[FLG_BOR]);

    assert_quiet_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!we_i && !bor_i && !pd_i && !to_i && !ri_i && !stk_i) |=> $stable(status_o));

endmodule

// File: rtl/rstc_seq.sv
module rstc_seq
    import rstc_pkg::*;
#(
    parameter int PWRT_BITS = 11,
    parameter int OST_BITS  = 10,
    parameter int SHORT_CYC = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  evt_t evt_i,
    output logic chip_rst_o
);

    localparam int MAX_PO = (PWRT_BITS > OST_BITS) ? PWRT_BITS : OST_BITS;
    localparam int SH_W   = $clog2(SHORT_CYC + 1);
    localparam int CNT_W  = (MAX_PO > SH_W) ? MAX_PO : SH_W;
    localparam logic [CNT_W-1:0] PW_LAST    = CNT_W'((1 << PWRT_BITS) - 1);
    localparam logic [CNT_W-1:0] OST_LAST   = CNT_W'((1 << OST_BITS) - 1);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_CYC - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             su;   // start-up timers owed after the hold
        logic             rst;
    } seq_t;

    localparam seq_t SEQ_RST = '{state: ST_PWRT, cnt: '0, su: 1'b1, rst: 1'b1};

    seq_t s_d, s_q;
    logic any_evt;

    assign any_evt = |evt_i;

    always_comb begin
        s_d = s_q;
        if (any_evt) begin
            s_d.state = ST_HOLD;
            s_d.cnt   = '0;
            if (s_q.state == ST_PWRT || s_q.state == ST_OST) s_d.su = 1'b1;
            else if (s_q.state != ST_HOLD)                   s_d.su = 1'b0;
            if (evt_i.bor) s_d.su = 1'b1;
        end else begin
            unique case (s_q.state)
                ST_HOLD: begin
                    s_d.cnt   = '0;
                    s_d.state = s_q.su ? ST_PWRT : ST_SHORT;
                end
                ST_PWRT: begin
                    if (tick_i) begin
                        if (s_q.cnt == PW_LAST) begin
                            s_d.state = ST_OST;
                            s_d.cnt   = '0;
                        end else begin
                            s_d.cnt = s_q.cnt + CNT_W'(1);
                        end
                    end
                end
                ST_OST: begin
                    if (s_q.cnt == OST_LAST) begin
                        s_d.state = ST_RUN;
                        s_d.cnt   = '0;
                        s_d.su    = 1'b0;
                    end else begin
                        s_d.cnt = s_q.cnt + CNT_W'(1);
                    end
                end
                ST_SHORT: begin
                    if (s_q.cnt == SHORT_LAST) begin
                        s_d.state = ST_RUN;
                        s_d.cnt   = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + CNT_W'(1);
                    end
                end
                default: s_d.cnt = '0;
            endcase
        end
        s_d.rst = (s_d.state != ST_RUN);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= SEQ_RST;
        else         s_q <= s_d;
    end

    assign chip_rst_o = s_q.rst;

    assert_evt_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        any_evt |=> chip_rst_o);

    assert_release_path_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(chip_rst_o) |-> ($past(s_q.state) == ST_OST || $past(s_q.state) == ST_SHORT));

    assert_pwrt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.state == ST_PWRT) |-> (s_q.cnt <= PW_LAST));

    assert_startup_kept_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (any_evt && (s_q.state == ST_PWRT || s_q.state == ST_OST)) |=> s_q.su);

endmodule

// File: rtl/rst_ctrl.sv
module rst_ctrl
    import rstc_pkg::*;
#(
    parameter int PWRT_BITS   = 11,
    parameter int OST_BITS    = 10,
    parameter int SHORT_CYC   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk_i,
    input  logic                por_ni,
    input  logic                tick_i,
    input  logic                ext_rst_ni,
    input  logic                cfg_extpin_en_i,
    input  logic                lowpwr_i,
    input  logic [1:0]          cfg_bor_sel_i,
    input  logic                bor_evt_i,
    input  logic                wdt_evt_i,
    input  logic                rst_instr_i,
    input  logic                stk_full_i,
    input  logic                stk_unf_i,
    input  logic                sw_we_i,
    input  logic [STATUS_W-1:0] sw_wdata_i,
    output logic [STATUS_W-1:0] status_o,
    output logic                chip_rst_o
);

    localparam int NSRC = 7;

    logic            rst_n_int;
    logic [NSRC-1:0] raw, synced;
    logic            pin_act, bor_en;
    evt_t            evt;

    // power-on: asserted asynchronously, released through a synchronizer
    rstc_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_por_sync (
        .clk_i  (clk_i),
        .rst_ni (por_ni),
        .d_i    (1'b1),
        .q_o    (rst_n_int)
    );

    assign raw = {lowpwr_i, stk_unf_i, stk_full_i, rst_instr_i,
                  wdt_evt_i, bor_evt_i, ~ext_rst_ni};

    rstc_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) u_evt_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_n_int),
        .d_i    (raw),
        .q_o    (synced)
    );

    always_comb begin
        pin_act    = synced[0] & cfg_extpin_en_i;
        bor_en     = cfg_bor_sel_i[1] | ((cfg_bor_sel_i == 2'b01) & status_o[CTL_SBOR]);
        evt.bor    = synced[1] & bor_en;
        evt.wdt    = synced[2];
        evt.ri     = synced[3];
        evt.stk    = synced[4] | synced[5];
        evt.pin    = pin_act & ~synced[6];
        evt.pin_lp = pin_act &  synced[6];
    end

    rstc_seq #(
        .PWRT_BITS (PWRT_BITS),
        .OST_BITS  (OST_BITS),
        .SHORT_CYC (SHORT_CYC)
    ) u_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_n_int),
        .tick_i     (tick_i),
        .evt_i      (evt),
        .chip_rst_o (chip_rst_o)
    );

    rstc_flags u_flags (
        .clk_i    (clk_i),
        .rst_ni   (rst_n_int),
        .bor_i    (evt.bor),
        .pd_i     (evt.pin_lp),
        .to_i     (evt.wdt),
        .ri_i     (evt.ri),
        .stk_i    (evt.stk),
        .we_i     (sw_we_i),
        .wdata_i  (sw_wdata_i),
        .status_o (status_o)
    );

endmodule

// File: tb/tb_rst_ctrl.sv
module tb_rst_ctrl;

    localparam int PWB = 3;
    localparam int OSB = 4;
    localparam int SHC = 4;
    localparam int TP  = 3;

    logic       clk = 1'b0;
    logic       por_n, tick, ext_rst_n, cfg_ext, lowpwr;
    logic [1:0] bor_sel;
    logic       bor, wdt, ri, full, unf, we;
    logic [7:0] wdata, status;
    logic       chip_rst;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    rst_ctrl #(.PWRT_BITS(PWB), .OST_BITS(OSB), .SHORT_CYC(SHC), .SYNC_STAGES(2)) dut (
        .clk_i(clk), .por_ni(por_n), .tick_i(tick), .ext_rst_ni(ext_rst_n),
        .cfg_extpin_en_i(cfg_ext), .lowpwr_i(lowpwr), .cfg_bor_sel_i(bor_sel),
        .bor_evt_i(bor), .wdt_evt_i(wdt), .rst_instr_i(ri), .stk_full_i(full),
        .stk_unf_i(unf), .sw_we_i(we), .sw_wdata_i(wdata), .status_o(status),
        .chip_rst_o(chip_rst)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected number of rising edges from source release to reset release
    function automatic int exp_rel(input bit su, input int first);
        int cnt = 0;
        if (!su) return SHC + 3;
        for (int e = first; e < 10000; e++) begin
            if (e % TP == 0) begin
                cnt++;
                if (cnt == (1 << PWB)) return e + (1 << OSB);
            end
        end
        return -1;
    endfunction

    task automatic set_src(input int idx, input bit v);
        case (idx)
            0: ext_rst_n = !v;
            1: bor  = v;
            2: wdt  = v;
            3: ri   = v;
            4: full = v;
            default: unf = v;
        endcase
    endtask

    task automatic measure(input bit su, output int edges);
        edges = -1;
        for (int e = 1; e <= 600; e++) begin
            tick = su && (e % TP == 0);
            @(posedge clk);
            @(negedge clk);
            if (!chip_rst) begin
                edges = e;
                break;
            end
        end
        tick = 1'b0;
    endtask

    task automatic pulse(input int idx, input string req);
        @(negedge clk);
        set_src(idx, 1'b1);
        repeat (4) @(negedge clk);
        chk(chip_rst == 1'b1, req, int'(chip_rst), 1);
        set_src(idx, 1'b0);
    endtask

    task automatic ignored_pulse(input int idx, input string req);
        int bad = 0;
        @(negedge clk);
        set_src(idx, 1'b1);
        repeat (4) begin
            @(negedge clk);
            if (chip_rst) bad++;
        end
        set_src(idx, 1'b0);
        repeat (6) begin
            @(negedge clk);
            if (chip_rst) bad++;
        end
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic sw_write(input logic [7:0] v);
        @(negedge clk);
        we = 1'b1;
        wdata = v;
        @(negedge clk);
        we = 1'b0;
        chk(status == v, "R9 write", int'(status), int'(v));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int m;
        int idx_l [6] = '{0, 0, 2, 3, 4, 5};
        bit lp_l  [6] = '{0, 1, 0, 0, 0, 0};
        logic [7:0] mask_l [6] = '{8'h00, 8'h04, 8'h08, 8'h10, 8'h20, 8'h20};

        por_n = 1'b0; tick = 1'b0; ext_rst_n = 1'b1; cfg_ext = 1'b1; lowpwr = 1'b0;
        bor_sel = 2'b10; bor = 1'b0; wdt = 1'b0; ri = 1'b0; full = 1'b0; unf = 1'b0;
        we = 1'b0; wdata = 8'h00;

        // R1: power-on state
        repeat (3) @(negedge clk);
        chk(chip_rst == 1'b1, "R1 reset held", int'(chip_rst), 1);
        chk(status == 8'h7C, "R1 status", int'(status), 8'h7C);

        // R2: power-on release through both timers
        por_n = 1'b1;
        measure(1'b1, m);
        chk(m == exp_rel(1'b1, 3), "R2 por hold", m, exp_rel(1'b1, 3));

        // R9: software sets every flag
        sw_write(8'hFF);

        // R6, R7, R8, R10: short-hold sources and their flag encodings
        for (int k = 0; k < 6; k++) begin
            sw_write(8'hFF);
            lowpwr = lp_l[k];
            pulse(idx_l[k], "R6 held while active");
            measure(1'b0, m);
            chk(m == SHC + 3, "R6 short hold", m, SHC + 3);
            lowpwr = 1'b0;
            chk(status == (8'hFF & ~mask_l[k]), "R7 R8 R10 flag encoding",
                int'(status), int'(8'hFF & ~mask_l[k]));
        end

        // R3: brown-out always enabled
        sw_write(8'hFF);
        pulse(1, "R3 held while active");
        measure(1'b1, m);
        chk(m == exp_rel(1'b1, 4), "R3 bor hold", m, exp_rel(1'b1, 4));
        chk(status == 8'hFE, "R3 bor flag", int'(status), 8'hFE);

        // R4: brown-out gating modes
        bor_sel = 2'b00;
        sw_write(8'hFF);
        ignored_pulse(1, "R4 disabled mode");
        chk(status == 8'hFF, "R4 disabled status", int'(status), 8'hFF);
        bor_sel = 2'b01;
        sw_write(8'hBF);
        ignored_pulse(1, "R4 soft bit clear");
        chk(status == 8'hBF, "R4 soft bit clear status", int'(status), 8'hBF);
        sw_write(8'hFF);
        pulse(1, "R4 soft bit set held");
        measure(1'b1, m);
        chk(m == exp_rel(1'b1, 4), "R4 soft bit set hold", m, exp_rel(1'b1, 4));
        chk(status == 8'hFE, "R4 soft bit set status", int'(status), 8'hFE);
        bor_sel = 2'b11;
        sw_write(8'hFF);
        pulse(1, "R4 mode 3 held");
        measure(1'b1, m);
        chk(m == exp_rel(1'b1, 4), "R4 mode 3 hold", m, exp_rel(1'b1, 4));

        // R5: pin disabled by configuration
        cfg_ext = 1'b0;
        sw_write(8'hFF);
        lowpwr = 1'b1;
        ignored_pulse(0, "R5 pin disabled");
        lowpwr = 1'b0;
        chk(status == 8'hFF, "R5 pin disabled status", int'(status), 8'hFF);
        cfg_ext = 1'b1;

        // R11: watchdog arrives while the power-up timer runs
        bor_sel = 2'b10;
        sw_write(8'hFF);
        pulse(1, "R11 bor held");
        repeat (8) @(negedge clk);
        chk(chip_rst == 1'b1, "R11 in start-up", int'(chip_rst), 1);
        pulse(2, "R11 wdt held");
        measure(1'b1, m);
        chk(m == exp_rel(1'b1, 4), "R11 restart hold", m, exp_rel(1'b1, 4));
        chk(status == 8'hF6, "R11 status", int'(status), 8'hF6);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule